// File: doc/BRIEF.md
# Interrupt Level Aggregator

The block gathers thirteen peripheral interrupt lines into one 32-bit status word, gates that word with a 32-bit enable word, and presents the processor with a 3-bit priority level. Each line owns one fixed status bit. The bits are not contiguous, and each bit sits in one of three priority groups: 3, 5 or 6. A line does not drive its bit continuously. The bit follows the line only when the line changes. Between changes, software may overwrite the bit.

Software reaches both words through a simple 32-bit register port, where a write replaces the whole word. A separate strobe lets a neighbouring controller force the disk DMA status bit without toggling the disk DMA line. The level output names the highest group that still holds an enabled, active bit. It is registered, so it follows status and enable with a delay of one cycle.

Top module: `irq_level_agg`

## Requirements
- R1: When source line k goes from 0 to 1, its status bit is 1 after the next clock edge. The line index maps to the status bit as follows: 0 to bit 2, 1 to 3, 2 to 5, 3 to 7, 4 to 9, 5 to 10, 6 to 12, 7 to 17, 8 to 21, 9 to 23, 10 to 26, 11 to 27, 12 to 28.
- R2: When a source line goes from 1 to 0, its status bit is 0 after the next clock edge.
- R3: A write to address 0x7000 replaces the whole status word. Reading address 0x7000 returns the status word.
- R4: A write to address 0x7800 replaces the whole enable word. Reading address 0x7800 returns the enable word.
- R5: A write to any other address changes neither word. A read of any other address returns 0.
- R6: A control strobe sets status bit 26 to the strobe's value bit, whatever the state of source line 10.
- R7: A status bit affects the level only while its enable bit is 1. With the enable word at 0, the level is 0.
- R8: The level is 6 if any enabled active bit lies in lines 8 to 12. Otherwise it is 5 if line 7's bit is enabled and active. Otherwise it is 3 if any bit of lines 0 to 6 is enabled and active. Otherwise it is 0. The level appears one edge after the edge that changes status or enable.
- R9: When a source line changes in the same cycle as a software write to the status word, the line's new level wins for its own bit. The write still sets every other bit.
- R10: After reset, both words and the level are 0.
- R11: When line 10 changes in the same cycle as a control strobe, line 10's new level wins for bit 26.
- R12: A line held steady does not restore its bit after software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Peripheral interrupt lines, level sensitive |
| ctl_we_i | input | 1 | Strobe that forces status bit 26 |
| ctl_val_i | input | 1 | Value written to bit 26 by the strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 16 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| level_o | output | 3 | Processor priority level |

## Verification
Two paths can update a status bit in the same cycle: a change on a source line, and either a software write to the status word or the bit-26 control strobe. The bench drives a rising or falling line together with a status write that carries the opposite value for that bit. It also lets line 10 fall while a strobe sets bit 26. It then reads the status word back through the register port and checks that the line's level holds in its own bit, while the write takes effect everywhere else.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC = 13;
  localparam int DW      = 32;
  localparam int LVL_W   = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // status bit owned by each source line
  function automatic int src_bit(input int i);
    case (i)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      3:       return 7;
      4:       return 9;
      5:       return 10;
      6:       return 12;
      7:       return 17;
      8:       return 21;
      9:       return 23;
      10:      return 26;
      11:      return 27;
      default: return 28;
    endcase
  endfunction

  function automatic int src_lvl(input int i);
    if (i < 7)       return 3;
    else if (i == 7) return 5;
    else             return 6;
  endfunction

  function automatic logic [DW-1:0] grp_mask(input int lvl);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_lvl(i) == lvl) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_src_track.sv
module irq_src_track
  import irq_agg_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int W  = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] val_o
);
  logic [N-1:0] src_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[g] <= 1'b0;
      else         src_q[g] <= src_i[g];
    end
  end

  // scatter line changes onto their status bits
  always_comb begin
    hit_o = '0;
    val_o = '0;
    for (int i = 0; i < N; i++) begin
      hit_o[src_bit(i)] = src_i[i] ^ src_q[i];
      val_o[src_bit(i)] = src_i[i];
    end
  end
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_agg_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output lvl_t         level_o
);
  localparam logic [W-1:0] G6 = W'(grp_mask(6));
  localparam logic [W-1:0] G5 = W'(grp_mask(5));
  localparam logic [W-1:0] G3 = W'(grp_mask(3));

  logic [W-1:0] live;
  lvl_t         level_d;

  assign live = status_i & mask_i;

  always_comb begin
    if      (|(live & G6)) level_d = 3'd6;
    else if (|(live & G5)) level_d = 3'd5;
    else if (|(live & G3)) level_d = 3'd3;
    else                   level_d = 3'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else         level_o <= level_d;
  end

  // R7
  masked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> (level_o == '0));

  // R8
  level_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> $past(|(status_i & mask_i)));
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter int               N_SRC     = NUM_SRC,
  parameter int               DATA_W    = DW,
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h7800,
  parameter int               CTL_BIT   = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              ctl_we_i,
  input  logic              ctl_val_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [2:0]        level_o
);
  logic [DATA_W-1:0] status_q, status_d, mask_q, mask_d;
  logic [DATA_W-1:0] hit, val;
  logic              wr_stat, wr_mask;

  assign wr_stat = reg_wr_i && (reg_addr_i == STAT_ADDR);
  assign wr_mask = reg_wr_i && (reg_addr_i == MASK_ADDR);

  irq_src_track #(.N(N_SRC), .W(DATA_W)) u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .hit_o (hit),
    .val_o (val)
  );

  // priority per bit: line change > control strobe > software write
  always_comb begin
    status_d = status_q;
    if (wr_stat)  status_d = reg_wdata_i;
    if (ctl_we_i) status_d[CTL_BIT] = ctl_val_i;
    status_d = (status_d & ~hit) | (val & hit);
    mask_d   = wr_mask ? reg_wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    if      (reg_addr_i == STAT_ADDR) reg_rdata_o = status_q;
    else if (reg_addr_i == MASK_ADDR) reg_rdata_o = mask_q;
    else                              reg_rdata_o = '0;
  end

  irq_level_enc #(.W(DATA_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_q),
    .mask_i  (mask_q),
    .level_o (level_o)
  );

  // R1 R2 R9
  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    localparam int B = src_bit(g);
    src_ev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[B] |=> (status_q[B] == $past(val[B])));
  end

  // R3
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !(|hit) && !ctl_we_i) |=> (status_q == $past(reg_wdata_i)));

  // R4
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(reg_wdata_i)));

  // R5
  other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !wr_stat && !wr_mask && !(|hit) && !ctl_we_i)
      |=> ($stable(status_q) && $stable(mask_q)));

  // R6
  ctl_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !hit[CTL_BIT]) |=> (status_q[CTL_BIT] == $past(ctl_val_i)));
endmodule

// File: tb/irq_level_agg_tb_top.sv
module irq_level_agg_tb_top;
  localparam logic [15:0] A_STAT = 16'h7000;
  localparam logic [15:0] A_MASK = 16'h7800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = '0;
  logic        ctl_we = 1'b0, ctl_val = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_level_agg dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .ctl_we_i   (ctl_we),
    .ctl_val_i  (ctl_val),
    .reg_wr_i   (reg_wr),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .level_o    (level)
  );

  function automatic int bit_of(input int k);
    int t[13] = '{2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28};
    return t[k];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); chk("R10 status", d, 32'h0);
    rd(A_MASK, d); chk("R10 mask", d, 32'h0);
    chk("R10 level", {29'b0, level}, 32'h0);
  endtask

  task automatic t_bitmap();
    logic [31:0] d;
    for (int k = 0; k < 13; k++) begin
      src[k] = 1'b1; step();
      rd(A_STAT, d); chk("R1 rise sets bit", d, 32'h1 << bit_of(k));
      src[k] = 1'b0; step();
      rd(A_STAT, d); chk("R2 fall clears bit", d, 32'h0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_STAT, 32'hA5A5_0F0F);
    rd(A_STAT, d); chk("R3 status write", d, 32'hA5A5_0F0F);
    wr(A_MASK, 32'h5A5A_F0F0);
    rd(A_MASK, d); chk("R4 mask write", d, 32'h5A5A_F0F0);
    wr(A_STAT, 32'h0); wr(A_MASK, 32'h0);
    rd(A_STAT, d); chk("R3 status cleared", d, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(16'h7004, 32'hFFFF_FFFF);
    wr(16'h7804, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R5 status untouched", d, 32'h0);
    rd(A_MASK, d); chk("R5 mask untouched", d, 32'h0);
    rd(16'h7004, d); chk("R5 other read", d, 32'h0);
  endtask

  task automatic t_ctl();
    logic [31:0] d;
    ctl_we = 1'b1; ctl_val = 1'b1; step(); ctl_we = 1'b0;
    rd(A_STAT, d); chk("R6 strobe sets bit26", d, 32'h1 << 26);
    ctl_we = 1'b1; ctl_val = 1'b0; step(); ctl_we = 1'b0;
    rd(A_STAT, d); chk("R6 strobe clears bit26", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    src[1] = 1'b1; src[7] = 1'b1; src[9] = 1'b1;
    step(); step();
    chk("R7 all masked", {29'b0, level}, 32'd0);
    wr(A_MASK, 32'hFFFF_FFFF);
    chk("R8 latency before", {29'b0, level}, 32'd0);
    step();
    chk("R8 group 6", {29'b0, level}, 32'd6);
    wr(A_MASK, ~(32'h1 << 23)); step();
    chk("R8 group 5", {29'b0, level}, 32'd5);
    wr(A_MASK, 32'h1 << 3); step();
    chk("R7 R8 group 3 only", {29'b0, level}, 32'd3);
    wr(A_MASK, (32'h1 << 17) | (32'h1 << 2)); step();
    chk("R8 group 5 again", {29'b0, level}, 32'd5);
    src = '0; step(); step();
    chk("R8 none active", {29'b0, level}, 32'd0);
    rd(A_STAT, d); chk("R2 all cleared", d, 32'h0);
    wr(A_MASK, 32'h0);
  endtask

  task automatic t_src_vs_wr();
    logic [31:0] d;
    src[0] = 1'b1;
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 rise beats write", d, 32'h1 << 2);
    src[0] = 1'b0;
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R9 fall beats write", d, ~(32'h1 << 2));
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_ctl_race();
    logic [31:0] d;
    src[10] = 1'b1; step();
    rd(A_STAT, d); chk("R1 disk dma set", d, 32'h1 << 26);
    src[10] = 1'b0; ctl_we = 1'b1; ctl_val = 1'b1;
    step(); ctl_we = 1'b0;
    rd(A_STAT, d); chk("R11 line beats strobe", d, 32'h0);
  endtask

  task automatic t_steady();
    logic [31:0] d;
    src[4] = 1'b1; step();
    rd(A_STAT, d); chk("R1 net rx set", d, 32'h1 << 9);
    wr(A_STAT, 32'h0); step(); step();
    rd(A_STAT, d); chk("R12 steady line no restore", d, 32'h0);
    src[4] = 1'b0; step();
    rd(A_STAT, d); chk("R2 after steady", d, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_bitmap();
    t_regs();
    t_ignored();
    t_ctl();
    t_level();
    t_src_vs_wr();
    t_ctl_race();
    t_steady();
    finish_run();
  end
endmodule